// File: doc/BRIEF.md
# Compressed Conditional Branch Resolver

This unit handles the two conditional branches of an early 16-bit compressed instruction encoding: branch-if-equal and branch-if-not-equal. It looks at a halfword instruction and decides whether it is one of these two branches. It turns the two 3-bit compact register selectors into full 5-bit register numbers, which drive the register-file read ports. It compares the operand values that come back and produces a taken flag and a PC-relative target.

The unit is purely combinational and sits between decode and the next-PC mux. It has no clock and no reset. When the compressed extension is switched off, a matching opcode raises an illegal-instruction flag in place of a branch. A mode input chooses between two comparisons: the full 64-bit register width, or the low 32 bits sign-extended.

Top module: `cbr_unit`

## Requirements
- R1: A branch is recognised when insn_i[4:0] is 5'h10 (equal branch) or 5'h11 (not-equal branch), whatever insn_i[6:5] hold. br_valid_o is 1 for a recognised branch while cen_i is 1, and 0 otherwise.
- R2: rs1_idx_o comes from the compact index in insn_i[12:10]. Index 0 maps to register 20, index 1 to register 21, and index k for k = 2..7 maps to register k.
- R3: rs2_idx_o comes from the compact index in insn_i[15:13]. It uses the same mapping as R2, except that index 7 maps to register 0.
- R4: target_o equals pc_i plus the 5-bit field insn_i[9:5], sign-extended and shifted left by one, taken modulo 2^64. The offsets -16 and +15 give -32 and +30 bytes.
- R5: For a valid equal branch, taken_o is 1 exactly when the compared operands match.
- R6: For a valid not-equal branch, taken_o is 1 exactly when the compared operands differ.
- R7: With word_cmp_i = 1, only bits 31:0 of each operand take part in the comparison, sign-extended. With word_cmp_i = 0, all 64 bits take part.
- R8: With cen_i = 0, a recognised branch sets illegal_o to 1 and forces br_valid_o and taken_o to 0. illegal_o is 0 in all other cases.
- R9: For an instruction that is not one of the two branches, taken_o is 0 whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn_i | input | 16 | Compressed instruction halfword |
| pc_i | input | 64 | Address of the instruction |
| rs1_val_i | input | 64 | Operand read through rs1_idx_o |
| rs2_val_i | input | 64 | Operand read through rs2_idx_o |
| cen_i | input | 1 | Compressed extension enabled |
| word_cmp_i | input | 1 | 1: compare the low 32 bits sign-extended; 0: compare the full width |
| br_valid_o | output | 1 | Enabled compressed conditional branch present |
| illegal_o | output | 1 | Branch opcode seen while the extension is disabled |
| rs1_idx_o | output | 5 | First source register number |
| rs2_idx_o | output | 5 | Second source register number |
| taken_o | output | 1 | Branch condition holds |
| target_o | output | 64 | Branch target address |

## Verification
The unit contains no register, so every output is due in the same cycle as the inputs that produce it, with zero cycles of latency. The bench changes all inputs on a falling clock edge and samples every output 2 ns later, well before the next rising edge. Each check therefore sees the settled response to exactly one stimulus. The operand values it returns are given in the same step as the instruction, which models the register file answering within the cycle.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

  // Low five opcode bits shared by both branches; bit 0 picks the sense.
  localparam logic [3:0] CBR_OPC_HI4 = 4'h8;

  typedef enum logic [1:0] {
    CBR_NONE = 2'd0,
    CBR_EQ   = 2'd1,
    CBR_NE   = 2'd2
  } cbr_kind_e;

  localparam int unsigned CIDX_W = 3;
  localparam int unsigned RIDX_W = 5;
  localparam int unsigned OFF_W  = 5;

  // Compact selector to architectural register number.
  function automatic logic [RIDX_W-1:0] cbr_map_cidx(input logic [CIDX_W-1:0] c,
                                                      input logic zero_last);
    logic [RIDX_W-1:0] r;
    case (c)
      3'd0:    r = 5'd20;
      3'd1:    r = 5'd21;
      3'd7:    r = zero_last ? 5'd0 : 5'd7;
      default: r = {2'b00, c};
    endcase
    return r;
  endfunction

endpackage

// File: rtl/cbr_opdec.sv
module cbr_opdec
  import cbr_pkg::*;
(
  input  logic [6:0] op_i,
  input  logic       cen_i,
  output cbr_kind_e  kind_o,
  output logic       valid_o,
  output logic       illegal_o
);

  logic hit;
  logic unused_opc_hi;

  // Bits 6:5 of the major opcode do not take part in recognition.
  assign unused_opc_hi = ^op_i[6:5];
  assign hit           = (op_i[4:1] == CBR_OPC_HI4);

  always_comb begin
    kind_o = CBR_NONE;
    if (hit && cen_i) begin
      kind_o = op_i[0] ? CBR_NE : CBR_EQ;
    end
  end

  assign valid_o   = hit &  cen_i;
  assign illegal_o = hit & ~cen_i;

endmodule

// File: rtl/cbr_regmap.sv
module cbr_regmap
  import cbr_pkg::*;
#(
  parameter bit ZERO_LAST = 1'b0
) (
  input  logic [CIDX_W-1:0] cidx_i,
  output logic [RIDX_W-1:0] ridx_o
);

  generate
    if (ZERO_LAST) begin : g_zero_last
      assign ridx_o = cbr_map_cidx(cidx_i, 1'b1);
    end else begin : g_plain
      assign ridx_o = cbr_map_cidx(cidx_i, 1'b0);
    end
  endgenerate

endmodule

// File: rtl/cbr_compare.sv
module cbr_compare
  import cbr_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned WORD_W = 32
) (
  input  logic [XLEN-1:0] a_i,
  input  logic [XLEN-1:0] b_i,
  input  logic            word_i,
  input  cbr_kind_e       kind_i,
  output logic            taken_o
);

  logic [XLEN-1:0] a_cmp;
  logic [XLEN-1:0] b_cmp;
  logic            same;

  generate
    if (XLEN > WORD_W) begin : g_trunc
      localparam int unsigned EXT_W = XLEN - WORD_W;
      logic [XLEN-1:0] a_word;
      logic [XLEN-1:0] b_word;
      assign a_word = {{EXT_W{a_i[WORD_W-1]}}, a_i[WORD_W-1:0]};
      assign b_word = {{EXT_W{b_i[WORD_W-1]}}, b_i[WORD_W-1:0]};
      assign a_cmp  = word_i ? a_word : a_i;
      assign b_cmp  = word_i ? b_word : b_i;
    end else begin : g_full
      logic unused_word;
      assign unused_word = word_i;
      assign a_cmp = a_i;
      assign b_cmp = b_i;
    end
  endgenerate

  assign same = (a_cmp == b_cmp);

  always_comb begin
    case (kind_i)
      CBR_EQ:  taken_o = same;
      CBR_NE:  taken_o = ~same;
      default: taken_o = 1'b0;
    endcase
  end

endmodule

// File: rtl/cbr_target.sv
module cbr_target #(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned OFF_W = 5,
  parameter int unsigned ALIGN = 1
) (
  input  logic [XLEN-1:0]  pc_i,
  input  logic [OFF_W-1:0] off_i,
  output logic [XLEN-1:0]  target_o
);

  localparam int unsigned EXT_W = XLEN - OFF_W;

  logic [XLEN-1:0] off_sx;

  assign off_sx   = {{EXT_W{off_i[OFF_W-1]}}, off_i};
  assign target_o = pc_i + (off_sx << ALIGN);

endmodule

// File: rtl/cbr_unit.sv
module cbr_unit
  import cbr_pkg::*;
#(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned WORD_W = 32,
  parameter int unsigned ALIGN  = 1
) (
  input  logic [15:0]       insn_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   rs1_val_i,
  input  logic [XLEN-1:0]   rs2_val_i,
  input  logic              cen_i,
  input  logic              word_cmp_i,
  output logic              br_valid_o,
  output logic              illegal_o,
  output logic [RIDX_W-1:0] rs1_idx_o,
  output logic [RIDX_W-1:0] rs2_idx_o,
  output logic              taken_o,
  output logic [XLEN-1:0]   target_o
);

  cbr_kind_e kind;

  cbr_opdec u_opdec (
    .op_i      (insn_i[6:0]),
    .cen_i     (cen_i),
    .kind_o    (kind),
    .valid_o   (br_valid_o),
    .illegal_o (illegal_o)
  );

  cbr_regmap #(.ZERO_LAST(1'b0)) u_map_rs1 (
    .cidx_i (insn_i[12:10]),
    .ridx_o (rs1_idx_o)
  );

  cbr_regmap #(.ZERO_LAST(1'b1)) u_map_rs2 (
    .cidx_i (insn_i[15:13]),
    .ridx_o (rs2_idx_o)
  );

  cbr_compare #(.XLEN(XLEN), .WORD_W(WORD_W)) u_cmp (
    .a_i     (rs1_val_i),
    .b_i     (rs2_val_i),
    .word_i  (word_cmp_i),
    .kind_i  (kind),
    .taken_o (taken_o)
  );

  cbr_target #(.XLEN(XLEN), .OFF_W(OFF_W), .ALIGN(ALIGN)) u_tgt (
    .pc_i     (pc_i),
    .off_i    (insn_i[9:5]),
    .target_o (target_o)
  );

endmodule

// File: rtl/cbr_unit_chk.sv
module cbr_unit_chk #(
  parameter int unsigned XLEN   = 64,
  parameter int unsigned WORD_W = 32
) (
  input logic [15:0]     insn_i,
  input logic [XLEN-1:0] rs1_val_i,
  input logic [XLEN-1:0] rs2_val_i,
  input logic            cen_i,
  input logic            word_cmp_i,
  input logic            br_valid_o,
  input logic            illegal_o,
  input logic [4:0]      rs1_idx_o,
  input logic [4:0]      rs2_idx_o,
  input logic            taken_o
);

  logic low_same;
  logic full_same;

  assign low_same  = (rs1_val_i[WORD_W-1:0] == rs2_val_i[WORD_W-1:0]);
  assign full_same = (rs1_val_i == rs2_val_i);

  always_comb begin
    // R8: disabled extension never yields a branch
    a_r8_illegal_blocks: assert (!(illegal_o && (br_valid_o || taken_o)))
      else $error("a_r8_illegal_blocks");
    // R8: illegal only when the extension is off
    a_r8_only_when_off: assert (!(illegal_o && cen_i))
      else $error("a_r8_only_when_off");
    // R9: taken only for a valid branch
    a_r9_no_take_idle: assert (br_valid_o || !taken_o)
      else $error("a_r9_no_take_idle");
    // R2: rs1 never lands outside its table
    a_r2_rs1_range: assert (rs1_idx_o inside {5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd7, 5'd20, 5'd21})
      else $error("a_r2_rs1_range");
    // R3: rs2 never lands outside its table
    a_r3_rs2_range: assert (rs2_idx_o inside {5'd0, 5'd2, 5'd3, 5'd4, 5'd5, 5'd6, 5'd20, 5'd21})
      else $error("a_r3_rs2_range");
    // R7: in word mode matching low halves decide as equal
    a_r7_word_equal: assert (!(br_valid_o && word_cmp_i && low_same) || (taken_o == !insn_i[0]))
      else $error("a_r7_word_equal");
    // R5 / R6: full-width sense
    a_r5_r6_full_sense: assert (!(br_valid_o && !word_cmp_i) || (taken_o == (full_same ^ insn_i[0])))
      else $error("a_r5_r6_full_sense");
  end

endmodule

bind cbr_unit cbr_unit_chk #(.XLEN(XLEN), .WORD_W(WORD_W)) u_chk (
  .insn_i     (insn_i),
  .rs1_val_i  (rs1_val_i),
  .rs2_val_i  (rs2_val_i),
  .cen_i      (cen_i),
  .word_cmp_i (word_cmp_i),
  .br_valid_o (br_valid_o),
  .illegal_o  (illegal_o),
  .rs1_idx_o  (rs1_idx_o),
  .rs2_idx_o  (rs2_idx_o),
  .taken_o    (taken_o)
);

// File: tb/tb_cbr_unit.sv
module tb_cbr_unit;

  logic        clk;
  logic        rst_n;
  logic [15:0] insn;
  logic [63:0] pc;
  logic [63:0] va;
  logic [63:0] vb;
  logic        cen;
  logic        wcmp;
  logic        br_valid;
  logic        illegal;
  logic [4:0]  rs1_idx;
  logic [4:0]  rs2_idx;
  logic        taken;
  logic [63:0] target;

  int n_checks;
  int n_fail;
  bit done;

  cbr_unit dut (
    .insn_i     (insn),
    .pc_i       (pc),
    .rs1_val_i  (va),
    .rs2_val_i  (vb),
    .cen_i      (cen),
    .word_cmp_i (wcmp),
    .br_valid_o (br_valid),
    .illegal_o  (illegal),
    .rs1_idx_o  (rs1_idx),
    .rs2_idx_o  (rs2_idx),
    .taken_o    (taken),
    .target_o   (target)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  typedef struct packed {
    logic [15:0] insn;
    logic [63:0] a;
    logic [63:0] b;
    logic        en;
    logic        word;
    logic        exp_valid;
    logic        exp_taken;
    logic        exp_ill;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{16'h0010, 64'd5, 64'd5, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},                       // R5 eq match
    '{16'h0030, 64'd5, 64'd6, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},                       // R5 eq differ
    '{16'h0031, 64'd5, 64'd6, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0},                       // R6 ne differ
    '{16'h0051, 64'd9, 64'd9, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},                       // R6 ne match
    '{16'h0070, 64'h1_0000_0007, 64'h7, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0},             // R7 word eq
    '{16'h0070, 64'h1_0000_0007, 64'h7, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0},             // R7 full eq
    '{16'h0071, 64'hFFFF_FFFF_8000_0000, 64'h0000_0000_8000_0000, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0}, // R7 wrap
    '{16'h0071, 64'hFFFF_FFFF_8000_0000, 64'h0000_0000_8000_0000, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0}, // R7 full ne
    '{16'h0010, 64'd3, 64'd3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1},                       // R8 disabled
    '{16'h0013, 64'd1, 64'd2, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0},                       // R9 other op
    '{16'h0012, 64'd4, 64'd4, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}                        // R9/R1 other op
  };

  function automatic logic [4:0] ref_map(input logic [2:0] c, input bit second);
    if (c == 3'd0) return 5'd20;
    if (c == 3'd1) return 5'd21;
    if (second && c == 3'd7) return 5'd0;
    return 5'(c);
  endfunction

  function automatic logic [63:0] ref_target(input logic [63:0] p, input logic [15:0] ins);
    longint off;
    off = longint'($signed(ins[9:5]));
    return p + 64'(off * 2);
  endfunction

  task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] i, input logic [63:0] p, input logic [63:0] a,
                       input logic [63:0] b, input logic e, input logic w);
    @(negedge clk);
    insn = i; pc = p; va = a; vb = b; cen = e; wcmp = w;
    #2;
  endtask

  initial begin
    n_checks = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0;
    insn = '0; pc = '0; va = '0; vb = '0; cen = 1'b1; wcmp = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    // idle state while the bench holds reset
    check({63'd0, br_valid}, 64'd0, "R1 idle valid");
    check({63'd0, taken},    64'd0, "R9 idle taken");
    check({63'd0, illegal},  64'd0, "R8 idle illegal");
    @(negedge clk);
    rst_n = 1'b1;

    // vector table
    for (int k = 0; k < NV; k++) begin
      drive(VECS[k].insn, 64'h8000_1000, VECS[k].a, VECS[k].b, VECS[k].en, VECS[k].word);
      check({63'd0, br_valid}, {63'd0, VECS[k].exp_valid}, $sformatf("R1 vec%0d valid", k));
      check({63'd0, taken},    {63'd0, VECS[k].exp_taken}, $sformatf("R5/R6/R7/R9 vec%0d taken", k));
      check({63'd0, illegal},  {63'd0, VECS[k].exp_ill},   $sformatf("R8 vec%0d illegal", k));
    end

    // R1: bits 6:5 ignored for both senses
    for (int h = 0; h < 4; h++) begin
      drive({9'd0, 2'(h), 5'h11}, 64'h100, 64'd1, 64'd2, 1'b1, 1'b0);
      check({63'd0, br_valid}, 64'd1, "R1 hi bits ne valid");
      check({63'd0, taken},    64'd1, "R6 hi bits ne taken");
    end

    // R2 / R3: sweep all compact selectors
    for (int s1 = 0; s1 < 8; s1++) begin
      for (int s2 = 0; s2 < 8; s2++) begin
        drive({3'(s2), 3'(s1), 5'd0, 5'h10}, 64'h0, 64'd0, 64'd0, 1'b1, 1'b0);
        check({59'd0, rs1_idx}, {59'd0, ref_map(3'(s1), 1'b0)}, "R2 rs1 map");
        check({59'd0, rs2_idx}, {59'd0, ref_map(3'(s2), 1'b1)}, "R3 rs2 map");
      end
    end

    // R4: offset extremes and PC wraparound
    drive({6'd0, 5'b10000, 5'h10}, 64'h0000_0000_0000_1000, 64'd0, 64'd0, 1'b1, 1'b0);
    check(target, 64'h0000_0000_0000_0FE0, "R4 offset -16");
    check(target, ref_target(pc, insn), "R4 model -16");
    drive({6'd0, 5'b01111, 5'h11}, 64'h0000_0000_0000_1000, 64'd0, 64'd0, 1'b1, 1'b0);
    check(target, 64'h0000_0000_0000_101E, "R4 offset +15");
    drive({6'd0, 5'b10000, 5'h10}, 64'h0, 64'd0, 64'd0, 1'b1, 1'b0);
    check(target, 64'hFFFF_FFFF_FFFF_FFE0, "R4 wrap low");
    drive({6'd0, 5'b01111, 5'h10}, 64'hFFFF_FFFF_FFFF_FFF0, 64'd0, 64'd0, 1'b1, 1'b0);
    check(target, 64'h0000_0000_0000_000E, "R4 wrap high");
    for (int o = 0; o < 32; o++) begin
      drive({6'd0, 5'(o), 5'h11}, 64'h1234_5678_9ABC_DEF0, 64'd0, 64'd1, 1'b1, 1'b0);
      check(target, ref_target(pc, insn), "R4 offset sweep");
    end

    // R7: word mode, low halves differ
    drive(16'h0070, 64'h0, 64'h5555_5555_0000_0001, 64'h5555_5555_0000_0002, 1'b1, 1'b1);
    check({63'd0, taken}, 64'd0, "R7 word differ");
    // R8: disabled not-equal with differing operands
    drive(16'h0051, 64'h0, 64'd1, 64'd2, 1'b0, 1'b0);
    check({63'd0, taken},    64'd0, "R8 disabled ne taken");
    check({63'd0, illegal},  64'd1, "R8 disabled ne illegal");
    check({63'd0, br_valid}, 64'd0, "R8 disabled ne valid");
    // R8: non-branch with extension off is not illegal
    drive(16'h0013, 64'h0, 64'd1, 64'd2, 1'b0, 1'b0);
    check({63'd0, illegal}, 64'd0, "R8 other op off");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

endmodule